// File: doc/BRIEF.md
# Data Segment Load Privilege Checker

This block decides whether a selector may be loaded into a data-segment or stack-segment register. For each request it takes the target register class, the current privilege level, the selector and the attributes of the descriptor the selector points to. One cycle later it returns either a grant or the number of the fault vector to raise. Privilege levels are 2-bit values. Level 0 is the most privileged and level 3 the least. The requested privilege level is the low two bits of the selector.

The two register classes follow different rules. A stack load needs the selector's requested level, the current level and the descriptor level to be exactly equal. It also needs a writable data descriptor, and it has its own not-present vector. An ordinary data load compares the larger of the requested and current levels against the descriptor level. A readable conforming code segment skips the privilege comparison entirely. Privilege and type failures take priority over a descriptor that is not present.

Requests enter on a valid/ready pair and responses leave on a valid/ready pair. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty, or when its response is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged and no new request is accepted. With `rsp_ready` held high, the block takes one request every cycle.

Top module: `dsl_load_check`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rsp_valid` is low and `req_ready` is high.
- R2: A request accepted on a clock edge produces `rsp_valid` high after that edge. With `rsp_ready` high and no new request accepted, `rsp_valid` is low again after the next edge.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_grant` and `rsp_vector` do not change.
- R4: An ordinary data load of a data descriptor (writable or not, conforming bit ignored) or of a readable non-conforming code descriptor that is valid and present is granted if and only if max(RPL, CPL) <= DPL. Otherwise it faults with vector 13.
- R5: An ordinary data load of a readable conforming code descriptor that is valid and present is granted for every combination of CPL, RPL and DPL.
- R6: An ordinary data load of an execute-only code descriptor (`dsc_code`=1, `dsc_rw`=0) faults with vector 13.
- R7: A stack load is granted only when RPL == CPL == DPL and the descriptor is writable data (`dsc_code`=0, `dsc_rw`=1), the descriptor being valid and present. Any other privilege or type combination faults with vector 13.
- R8: A stack load that passes the privilege and type checks but whose descriptor has `dsc_present`=0 faults with vector 12.
- R9: An ordinary data load that passes the privilege and type checks but whose descriptor has `dsc_present`=0 faults with vector 11.
- R10: A descriptor with `dsc_valid`=0 faults with vector 13, whatever its other attributes are.
- R11: When a privilege or type check fails and the descriptor is also not present, the vector is 13.
- R12: A granted response has `rsp_grant`=1 and `rsp_vector`=0. A faulting response has `rsp_grant`=0 and a vector of 11, 12 or 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can take the presented request |
| req_stack | input | 1 | 1: target is the stack register; 0: an ordinary data register |
| req_cpl | input | 2 | Current privilege level |
| req_selector | input | 16 | Selector; its low two bits are the requested privilege level |
| dsc_dpl | input | 2 | Descriptor privilege level |
| dsc_present | input | 1 | Descriptor's segment is present |
| dsc_code | input | 1 | 1: code descriptor; 0: data descriptor |
| dsc_rw | input | 1 | Writable (data descriptor) or readable (code descriptor) |
| dsc_conform | input | 1 | Conforming code descriptor; ignored for data |
| dsc_valid | input | 1 | The descriptor fetch produced a usable descriptor |
| rsp_valid | output | 1 | A response is presented |
| rsp_ready | input | 1 | The consumer takes the presented response |
| rsp_grant | output | 1 | 1: load allowed |
| rsp_vector | output | 8 | Fault vector when not granted; 0 when granted |

## Verification
The assertions assume that the request attributes are meaningful only in cycles where `req_valid` is high. They also assume that `rsp_ready` may drop at any time, including in the same cycle a response first appears. The stimulus holds to this. It first sweeps every combination of register class, the three privilege levels, the descriptor type bits, the present flag and the valid flag with `rsp_ready` held high. It then sends random requests with random gaps while randomly stalling the consumer, so that held responses and refused requests both occur.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

  // Width of a fault vector number on the response.
  localparam int unsigned VEC_W = 8;

  // Outcome class chosen by the fault selector.
  typedef enum logic [1:0] {
    OUT_GRANT    = 2'd0,
    OUT_PRIV     = 2'd1,
    OUT_STACK_NP = 2'd2,
    OUT_DATA_NP  = 2'd3
  } outcome_e;

  // Registered response payload.
  typedef struct packed {
    logic             grant;
    logic [VEC_W-1:0] vector;
  } rsp_t;

endpackage

// File: rtl/dsl_level_cmp.sv
// Privilege level relations used by both register classes.
module dsl_level_cmp #(
  parameter int unsigned PL_W = 2
) (
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] rpl,
  input  logic [PL_W-1:0] dpl,
  output logic            all_equal,
  output logic            eff_le_dpl
);
  // The effective level is the weaker (numerically larger) of requester and caller.
  logic [PL_W-1:0] eff_pl;

  always_comb begin
    eff_pl     = (rpl > cpl) ? rpl : cpl;
    eff_le_dpl = (eff_pl <= dpl);
    all_equal  = (rpl == cpl) && (cpl == dpl);
  end
endmodule

// File: rtl/dsl_type_rules.sv
// Combines descriptor type with the level relations into one pass/fail flag.
module dsl_type_rules (
  input  logic is_stack,
  input  logic dsc_valid,
  input  logic dsc_code,
  input  logic dsc_rw,
  input  logic dsc_conform,
  input  logic all_equal,
  input  logic eff_le_dpl,
  output logic check_ok
);
  logic stack_ok;
  logic data_ok;
  logic exec_only;
  logic conf_read;

  always_comb begin
    exec_only = dsc_code && !dsc_rw;
    conf_read = dsc_code && dsc_rw && dsc_conform;
    // Stack path: writable data only, and the three levels must coincide.
    stack_ok  = !dsc_code && dsc_rw && all_equal;
    // Data path: execute-only code never loads; readable conforming code skips levels.
    if (exec_only)      data_ok = 1'b0;
    else if (conf_read) data_ok = 1'b1;
    else                data_ok = eff_le_dpl;
    check_ok = dsc_valid && (is_stack ? stack_ok : data_ok);
  end
endmodule

// File: rtl/dsl_fault_pick.sv
// Orders the outcome: privilege/type failure first, then absence, then grant.
module dsl_fault_pick
  import dsl_pkg::*;
#(
  parameter int unsigned V_PRIV     = 13,
  parameter int unsigned V_STACK_NP = 12,
  parameter int unsigned V_DATA_NP  = 11
) (
  input  logic     is_stack,
  input  logic     check_ok,
  input  logic     present,
  output outcome_e outcome,
  output rsp_t     rsp
);
  always_comb begin
    if (!check_ok)     outcome = OUT_PRIV;
    else if (!present) outcome = is_stack ? OUT_STACK_NP : OUT_DATA_NP;
    else               outcome = OUT_GRANT;

    rsp.grant = (outcome == OUT_GRANT);
    unique case (outcome)
      OUT_PRIV:     rsp.vector = VEC_W'(V_PRIV);
      OUT_STACK_NP: rsp.vector = VEC_W'(V_STACK_NP);
      OUT_DATA_NP:  rsp.vector = VEC_W'(V_DATA_NP);
      default:      rsp.vector = '0;
    endcase
  end
endmodule

// File: rtl/dsl_load_check.sv
// Top: request decode, combinational rule network, one-entry registered output stage.
module dsl_load_check
  import dsl_pkg::*;
#(
  parameter int unsigned SEL_W      = 16,
  parameter int unsigned PL_W       = 2,
  parameter int unsigned V_PRIV     = 13,
  parameter int unsigned V_STACK_NP = 12,
  parameter int unsigned V_DATA_NP  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_stack,
  input  logic [PL_W-1:0]  req_cpl,
  input  logic [SEL_W-1:0] req_selector,
  input  logic [PL_W-1:0]  dsc_dpl,
  input  logic             dsc_present,
  input  logic             dsc_code,
  input  logic             dsc_rw,
  input  logic             dsc_conform,
  input  logic             dsc_valid,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_grant,
  output logic [VEC_W-1:0] rsp_vector
);
  localparam int unsigned IDX_W = SEL_W - PL_W;

  logic [PL_W-1:0]  rpl;
  logic [IDX_W-1:0] sel_index_unused;
  logic             all_equal;
  logic             eff_le_dpl;
  logic             check_ok;
  outcome_e         outcome;
  rsp_t             rsp_next;
  rsp_t             rsp_q;
  logic             out_full;
  logic             take;

  // The requested level is carried in the selector's low bits; the index is not needed here.
  assign rpl              = req_selector[PL_W-1:0];
  assign sel_index_unused = req_selector[SEL_W-1:PL_W];

  dsl_level_cmp #(.PL_W(PL_W)) u_lvl (
    .cpl        (req_cpl),
    .rpl        (rpl),
    .dpl        (dsc_dpl),
    .all_equal  (all_equal),
    .eff_le_dpl (eff_le_dpl)
  );

  dsl_type_rules u_rules (
    .is_stack    (req_stack),
    .dsc_valid   (dsc_valid),
    .dsc_code    (dsc_code),
    .dsc_rw      (dsc_rw),
    .dsc_conform (dsc_conform),
    .all_equal   (all_equal),
    .eff_le_dpl  (eff_le_dpl),
    .check_ok    (check_ok)
  );

  dsl_fault_pick #(
    .V_PRIV     (V_PRIV),
    .V_STACK_NP (V_STACK_NP),
    .V_DATA_NP  (V_DATA_NP)
  ) u_pick (
    .is_stack (req_stack),
    .check_ok (check_ok),
    .present  (dsc_present),
    .outcome  (outcome),
    .rsp      (rsp_next)
  );

  // Output stage: accepts when empty or draining this cycle.
  assign req_ready = !out_full || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_full <= 1'b0;
      rsp_q    <= '0;
    end else begin
      if (req_ready) out_full <= req_valid;
      if (take)      rsp_q    <= rsp_next;
    end
  end

  assign rsp_valid  = out_full;
  assign rsp_grant  = rsp_q.grant;
  assign rsp_vector = rsp_q.vector;

endmodule

// File: rtl/dsl_load_check_sva.sv
module dsl_load_check_sva
  import dsl_pkg::*;
#(
  parameter int unsigned PL_W       = 2,
  parameter int unsigned V_PRIV     = 13,
  parameter int unsigned V_STACK_NP = 12,
  parameter int unsigned V_DATA_NP  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_stack,
  input logic [PL_W-1:0]  req_cpl,
  input logic [PL_W-1:0]  rpl,
  input logic [PL_W-1:0]  dsc_dpl,
  input logic             dsc_present,
  input logic             dsc_code,
  input logic             dsc_rw,
  input logic             dsc_valid,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_grant,
  input logic [VEC_W-1:0] rsp_vector
);
  logic accept;
  assign accept = req_valid && req_ready;

  // R1: in reset the stage is empty and open
  always_comb begin
    if (!rst_n) a_r1_reset_idle: assert (req_ready);
  end

  a_r2_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !accept) |=> !rsp_valid);

  a_r3_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_grant) && $stable(rsp_vector)));

  a_r12_grant_zero_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_grant) |-> (rsp_vector == '0));

  a_r12_fault_vector_known: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> (rsp_vector == VEC_W'(V_PRIV) ||
                                   rsp_vector == VEC_W'(V_STACK_NP) ||
                                   rsp_vector == VEC_W'(V_DATA_NP)));

  a_r10_invalid_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dsc_valid) |=> (!rsp_grant && rsp_vector == VEC_W'(V_PRIV)));

  a_r8_stack_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_stack && dsc_valid && !dsc_present && !dsc_code && dsc_rw &&
     rpl == req_cpl && req_cpl == dsc_dpl) |=> (rsp_vector == VEC_W'(V_STACK_NP)));

  a_r7_stack_code_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_stack && dsc_code) |=> (rsp_vector == VEC_W'(V_PRIV)));

endmodule

bind dsl_load_check dsl_load_check_sva #(
  .PL_W       (PL_W),
  .V_PRIV     (V_PRIV),
  .V_STACK_NP (V_STACK_NP),
  .V_DATA_NP  (V_DATA_NP)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_stack   (req_stack),
  .req_cpl     (req_cpl),
  .rpl         (rpl),
  .dsc_dpl     (dsc_dpl),
  .dsc_present (dsc_present),
  .dsc_code    (dsc_code),
  .dsc_rw      (dsc_rw),
  .dsc_valid   (dsc_valid),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_grant   (rsp_grant),
  .rsp_vector  (rsp_vector)
);

// File: tb/sim_dsl_load_check.sv
module sim_dsl_load_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_stack = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic [15:0] req_selector = '0;
  logic [1:0]  dsc_dpl = '0;
  logic        dsc_present = 1'b0;
  logic        dsc_code = 1'b0;
  logic        dsc_rw = 1'b0;
  logic        dsc_conform = 1'b0;
  logic        dsc_valid = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_grant;
  logic [7:0]  rsp_vector;

  int n_vec = 0;
  int n_bad = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dsl_load_check u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_stack(req_stack), .req_cpl(req_cpl), .req_selector(req_selector),
    .dsc_dpl(dsc_dpl), .dsc_present(dsc_present), .dsc_code(dsc_code),
    .dsc_rw(dsc_rw), .dsc_conform(dsc_conform), .dsc_valid(dsc_valid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_grant(rsp_grant),
    .rsp_vector(rsp_vector)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: returns expected vector (0 = grant) and the rule it exercises.
  function automatic int ref_vector(input bit stk, input int cpl, input int rpl, input int dpl,
                                    input bit code, input bit rw, input bit conf,
                                    input bit pres, input bit vld, output string tag);
    bit ok;
    int mx;
    if (!vld) begin tag = "R10"; return 13; end
    if (stk) begin
      ok = !code && rw && (rpl == cpl) && (cpl == dpl);
      tag = "R7";
    end else if (code && !rw) begin
      ok = 0; tag = "R6";
    end else if (code && conf) begin
      ok = 1; tag = "R5";
    end else begin
      mx = (rpl > cpl) ? rpl : cpl;
      ok = (mx <= dpl); tag = "R4";
    end
    if (!ok) begin
      if (!pres) tag = "R11";
      return 13;
    end
    if (!pres) begin
      tag = stk ? "R8" : "R9";
      return stk ? 12 : 11;
    end
    return 0;
  endfunction

  // One clock of stimulus plus comparison against the reference queue.
  task automatic cycle(input bit v, input bit stk, input int cpl, input int rpl, input int dpl,
                       input bit code, input bit rw, input bit conf, input bit pres,
                       input bit vld, input bit rdy);
    bit    mv;
    bit    acc;
    int    e;
    string t;
    @(negedge clk);
    req_valid    = v;
    req_stack    = stk;
    req_cpl      = 2'(cpl);
    req_selector = {14'($urandom), 2'(rpl)};
    dsc_dpl      = 2'(dpl);
    dsc_code     = code;
    dsc_rw       = rw;
    dsc_conform  = conf;
    dsc_present  = pres;
    dsc_valid    = vld;
    rsp_ready    = rdy;
    #1;
    mv = (exp_q.size() != 0);
    check(rsp_valid == mv, "R2", "rsp_valid", int'(rsp_valid), int'(mv));
    if (mv && rsp_valid) begin
      check(rsp_vector == 8'(exp_q[0]), tag_q[0], "rsp_vector", int'(rsp_vector), exp_q[0]);
      check(rsp_grant == (exp_q[0] == 0), "R12", "rsp_grant", int'(rsp_grant),
            int'(exp_q[0] == 0));
    end
    check(req_ready == (!mv || rdy), "R3", "req_ready", int'(req_ready), int'(!mv || rdy));
    acc = v && (!mv || rdy);
    if (mv && rdy) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (acc) begin
      e = ref_vector(stk, cpl, rpl, dpl, code, rw, conf, pres, vld, t);
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, with a request pending during reset
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

    // Exhaustive sweep, consumer always ready (R4..R12)
    for (int i = 0; i < 4096; i++) begin
      cycle(1'b1, i[0], i[2:1], i[4:3], i[6:5], i[7], i[8], i[9], i[10], i[11], 1'b1);
    end
    cycle(1'b0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1'b1);
    cycle(1'b0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1'b1);

    // Random traffic with gaps and consumer stalls (R2, R3)
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 4) != 0, 1'($urandom), int'($urandom % 4), int'($urandom % 4),
            int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 4) != 0, ($urandom % 8) != 0, ($urandom % 3) != 0);
    end
    for (int i = 0; i < 4; i++) cycle(1'b0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1'b1);
    finish_run();
  end
endmodule